// File: doc/BRIEF.md
# Pipelined DES Round Datapath

This block is the data half of a fully pipelined DES engine. It accepts one 64-bit block on every clock, qualified by a valid flag and a small sideband tag. Every block goes through the initial permutation and then through sixteen Feistel round stages. Each stage has its own registered left and right halves. The block then swaps the halves, applies the final permutation and registers the result. A block's tag and valid bit travel in lockstep with it, so the result comes out with the tag it went in with.

The block does not generate keys. A companion key pipeline drives a wide bus that carries one 48-bit subkey per round. It skews that bus so that each round stage sees the subkey belonging to the block it holds in that cycle. As a result, neighbouring blocks may use unrelated keys, and some may be encrypted while others are decrypted. Decryption uses the same datapath; the key side simply delivers the subkeys in reverse round order.

Port bit 63 is the first bit of the block in standard DES bit numbering, and the left half is the upper 32 bits after the initial permutation.

Top module: `des_pipe`

## Requirements
- R1: A synchronous active-high reset clears the valid bit of every stage. `out_valid` is low in the cycle after reset is sampled high, and it stays low until a block presented after reset has crossed the whole pipeline. The data registers are not reset.
- R2: A block presented with `in_valid` high at a rising edge produces `out_valid` high exactly 17 rising edges later, counting the capturing edge as the first. In every other cycle `out_valid` is low, and results leave in the order the blocks entered.
- R3: The pipeline never stalls. A valid block can be presented on every clock with no gaps, and each one yields its own correct result.
- R4: `out_tag` equals the `in_tag` value that was presented with the block now on `out_block`.
- R5: Round r+1 (r = 0..15) takes its subkey from `round_keys[r*48+47 : r*48]`. A block presented in cycle c uses slice r in cycle c+r. Consecutive blocks may therefore use different keys and directions.
- R6: With the subkeys in forward order (slice 0 = first round key), the block performs DES encryption: the initial permutation, sixteen rounds of expansion, subkey XOR, eight S-boxes and the P permutation XORed into the left half, then the half swap and the inverse permutation. Key 133457799BBCDFF1 with plaintext 0123456789ABCDEF gives 85E813540F0AB405.
- R7: With the subkeys in reverse order (slice 0 = sixteenth round key), the same datapath decrypts: 85E813540F0AB405 returns 0123456789ABCDEF under the key above.
- R8: While `in_valid` is low, `in_block`, `in_tag` and the subkeys for that slot produce no output: no `out_valid` pulse appears 17 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the block presented this cycle |
| in_tag | input | TAG_W (2) | Sideband value carried with the block |
| in_block | input | 64 | Plaintext or ciphertext block, bit 63 is DES bit 1 |
| round_keys | input | NUM_ROUNDS*48 (768) | Per-stage subkeys, slice r feeds round r+1 |
| out_valid | output | 1 | Result on `out_block` is valid |
| out_tag | output | TAG_W (2) | Tag of the block on `out_block` |
| out_block | output | 64 | Result block, registered |

## Verification
The hardest case to reach is sixteen stages that each hold a different block with a different key and direction, so that a skew error of one slot would corrupt a result without stopping the stream. The stimulus creates this case with long runs of back-to-back blocks that use fresh random keys and random directions. The bench skews the subkey bus the same way the key pipeline would, and in idle slots it drives garbage data together with zero keys. A reset raised while the pipeline is full is the other hard case: the bench asserts it in mid-stream and checks that none of the blocks in flight comes out afterwards.

// File: rtl/des_pipe_pkg.sv
package des_pipe_pkg;

  localparam int BLOCK_W  = 64;
  localparam int HALF_W   = 32;
  localparam int SUBKEY_W = 48;
  localparam int SBOX_CNT = 8;

  // Substitution tables: entry box*4+row, nibble for column c sits at [(15-c)*4 +: 4]
  localparam logic [63:0] SBOX_ROWS [32] = '{
    64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D,
    64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9,
    64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C,
    64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E,
    64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453,
    64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D,
    64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C,
    64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B
  };

  // Straight permutation after the substitution layer (1-based source bit per output bit)
  localparam int PERM_P [32] = '{
    16, 7, 20, 21, 29, 12, 28, 17, 1, 15, 23, 26, 5, 18, 31, 10,
    2, 8, 24, 14, 32, 27, 3, 9, 19, 13, 30, 6, 22, 11, 4, 25
  };

  // Source bit (1-based, 1 = MSB) of output position j of the initial permutation
  function automatic int ip_source(input int j);
    int row;
    int col;
    int start;
    row   = (j - 1) / 8;
    col   = (j - 1) % 8;
    start = (row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4));
    return start - 8 * col;
  endfunction

  function automatic logic [63:0] perm_initial(input logic [63:0] x);
    logic [63:0] y;
    y = '0;
    for (int j = 1; j <= 64; j++) y[64 - j] = x[64 - ip_source(j)];
    return y;
  endfunction

  function automatic logic [63:0] perm_final(input logic [63:0] x);
    logic [63:0] y;
    y = '0;
    for (int j = 1; j <= 64; j++) y[64 - ip_source(j)] = x[64 - j];
    return y;
  endfunction

  function automatic logic [47:0] expand(input logic [31:0] r);
    logic [47:0] y;
    y = '0;
    for (int g = 0; g < 8; g++) begin
      for (int k = 0; k < 6; k++) begin
        y[47 - (6 * g + k)] = r[32 - (((4 * g + k + 31) % 32) + 1)];
      end
    end
    return y;
  endfunction

  function automatic logic [31:0] perm_p(input logic [31:0] s);
    logic [31:0] y;
    y = '0;
    for (int p = 0; p < 32; p++) y[31 - p] = s[32 - PERM_P[p]];
    return y;
  endfunction

  function automatic logic [3:0] sbox_out(input int box, input logic [5:0] x);
    int row;
    int col;
    logic [63:0] line;
    row  = int'({x[5], x[0]});
    col  = int'(x[4:1]);
    line = SBOX_ROWS[box * 4 + row];
    return line[(15 - col) * 4 +: 4];
  endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox
  import des_pipe_pkg::*;
#(
  parameter int BOX_IDX = 0
) (
  input  logic [5:0] sel,
  output logic [3:0] nib
);

  assign nib = sbox_out(BOX_IDX, sel);

endmodule

// File: rtl/des_round_fn.sv
module des_round_fn
  import des_pipe_pkg::*;
(
  input  logic [HALF_W-1:0]   r_half,
  input  logic [SUBKEY_W-1:0] subkey,
  output logic [HALF_W-1:0]   f_out
);

  localparam int GRP_IN  = SUBKEY_W / SBOX_CNT;
  localparam int GRP_OUT = HALF_W / SBOX_CNT;

  logic [SUBKEY_W-1:0] mixed;
  logic [HALF_W-1:0]   subst;

  assign mixed = expand(r_half) ^ subkey;

  for (genvar g = 0; g < SBOX_CNT; g++) begin : g_box
    des_sbox #(.BOX_IDX(g)) u_box (
      .sel (mixed[SUBKEY_W-1-GRP_IN*g -: GRP_IN]),
      .nib (subst[HALF_W-1-GRP_OUT*g -: GRP_OUT])
    );
  end

  assign f_out = perm_p(subst);

endmodule

// File: rtl/des_round_stage.sv
module des_round_stage
  import des_pipe_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_in,
  input  logic [TAG_W-1:0]    tag_in,
  input  logic [HALF_W-1:0]   l_in,
  input  logic [HALF_W-1:0]   r_in,
  input  logic [SUBKEY_W-1:0] subkey,
  output logic                v_q,
  output logic [TAG_W-1:0]    tag_q,
  output logic [HALF_W-1:0]   l_q,
  output logic [HALF_W-1:0]   r_q
);

  logic [HALF_W-1:0] f_val;

  des_round_fn u_fn (
    .r_half (r_in),
    .subkey (subkey),
    .f_out  (f_val)
  );

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
  end

  // Data registers carry no reset: only the valid bit qualifies them
  always_ff @(posedge clk) begin
    tag_q <= tag_in;
    l_q   <= r_in;
    r_q   <= l_in ^ f_val;
  end

endmodule

// File: rtl/des_out_stage.sv
module des_out_stage
  import des_pipe_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               v_in,
  input  logic [TAG_W-1:0]   tag_in,
  input  logic [HALF_W-1:0]  l_in,
  input  logic [HALF_W-1:0]  r_in,
  output logic               v_q,
  output logic [TAG_W-1:0]   tag_q,
  output logic [BLOCK_W-1:0] blk_q
);

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
  end

  // Halves are swapped before the inverse permutation
  always_ff @(posedge clk) begin
    tag_q <= tag_in;
    blk_q <= perm_final({r_in, l_in});
  end

endmodule

// File: rtl/des_pipe.sv
module des_pipe
  import des_pipe_pkg::*;
#(
  parameter int NUM_ROUNDS = 16,
  parameter int TAG_W      = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [TAG_W-1:0]               in_tag,
  input  logic [BLOCK_W-1:0]             in_block,
  input  logic [NUM_ROUNDS*SUBKEY_W-1:0] round_keys,
  output logic                           out_valid,
  output logic [TAG_W-1:0]               out_tag,
  output logic [BLOCK_W-1:0]             out_block
);

  logic [NUM_ROUNDS:0] vld_chain;
  logic [TAG_W-1:0]    tag_chain [NUM_ROUNDS+1];
  logic [HALF_W-1:0]   l_chain   [NUM_ROUNDS+1];
  logic [HALF_W-1:0]   r_chain   [NUM_ROUNDS+1];
  logic [BLOCK_W-1:0]  ip_blk;

  assign ip_blk       = perm_initial(in_block);
  assign vld_chain[0] = in_valid;
  assign tag_chain[0] = in_tag;
  assign l_chain[0]   = ip_blk[BLOCK_W-1:HALF_W];
  assign r_chain[0]   = ip_blk[HALF_W-1:0];

  for (genvar s = 0; s < NUM_ROUNDS; s++) begin : g_round
    des_round_stage #(.TAG_W(TAG_W)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .v_in   (vld_chain[s]),
      .tag_in (tag_chain[s]),
      .l_in   (l_chain[s]),
      .r_in   (r_chain[s]),
      .subkey (round_keys[s*SUBKEY_W +: SUBKEY_W]),
      .v_q    (vld_chain[s+1]),
      .tag_q  (tag_chain[s+1]),
      .l_q    (l_chain[s+1]),
      .r_q    (r_chain[s+1])
    );
  end

  des_out_stage #(.TAG_W(TAG_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .v_in   (vld_chain[NUM_ROUNDS]),
    .tag_in (tag_chain[NUM_ROUNDS]),
    .l_in   (l_chain[NUM_ROUNDS]),
    .r_in   (r_chain[NUM_ROUNDS]),
    .v_q    (out_valid),
    .tag_q  (out_tag),
    .blk_q  (out_block)
  );

endmodule

// File: rtl/des_pipe_chk.sv
module des_pipe_chk #(
  parameter int NUM_ROUNDS = 16,
  parameter int TAG_W      = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [TAG_W-1:0]      in_tag,
  input logic [NUM_ROUNDS:0]   vld_chain,
  input logic                  out_valid,
  input logic [TAG_W-1:0]      out_tag
);

  localparam int LAT = NUM_ROUNDS + 1;

  logic [LAT-1:0]   v_sh;
  logic [TAG_W-1:0] t_sh [LAT];

  always_ff @(posedge clk) begin
    if (rst) v_sh <= '0;
    else     v_sh <= {v_sh[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    t_sh[0] <= in_tag;
    for (int k = 1; k < LAT; k++) t_sh[k] <= t_sh[k-1];
  end

  // R2: output valid follows input valid by exactly LAT edges
  assert_out_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sh[LAT-1]);

  // R4: tag leaves with the block it entered with
  assert_tag_follow_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_tag == t_sh[LAT-1]);

  // R1: reset empties the output
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && vld_chain[NUM_ROUNDS:1] == '0));

  // R3: each stage takes its neighbour's valid bit every clock, no stall
  for (genvar i = 1; i <= NUM_ROUNDS; i++) begin : g_shift
    assert_stage_advance_R3: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> vld_chain[i] == $past(vld_chain[i-1]));
  end

endmodule

bind des_pipe des_pipe_chk #(.NUM_ROUNDS(NUM_ROUNDS), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_tag    (in_tag),
  .vld_chain (vld_chain),
  .out_valid (out_valid),
  .out_tag   (out_tag)
);

// File: tb/tb_des_pipe.sv
module tb_des_pipe;
  import des_pipe_pkg::*;

  localparam int NR  = 16;
  localparam int TW  = 2;
  localparam int LAT = NR + 1;
  localparam int KSW = NR * 48;

  localparam int PC1_TAB [56] = '{
    57, 49, 41, 33, 25, 17, 9, 1, 58, 50, 42, 34, 26, 18,
    10, 2, 59, 51, 43, 35, 27, 19, 11, 3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15, 7, 62, 54, 46, 38, 30, 22,
    14, 6, 61, 53, 45, 37, 29, 21, 13, 5, 28, 20, 12, 4
  };
  localparam int PC2_TAB [48] = '{
    14, 17, 11, 24, 1, 5, 3, 28, 15, 6, 21, 10,
    23, 19, 12, 4, 26, 8, 16, 7, 27, 20, 13, 2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };
  localparam int ROT_TAB [16] = '{1, 1, 2, 2, 2, 2, 2, 2, 1, 2, 2, 2, 2, 2, 2, 1};

  localparam logic [63:0] KAT_KEY = 64'h133457799BBCDFF1;
  localparam logic [63:0] KAT_PT  = 64'h0123456789ABCDEF;
  localparam logic [63:0] KAT_CT  = 64'h85E813540F0AB405;

  logic           clk;
  logic           rst;
  logic           in_valid;
  logic [TW-1:0]  in_tag;
  logic [63:0]    in_block;
  logic [KSW-1:0] round_keys;
  logic           out_valid;
  logic [TW-1:0]  out_tag;
  logic [63:0]    out_block;

  des_pipe #(.NUM_ROUNDS(NR), .TAG_W(TW)) dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_tag     (in_tag),
    .in_block   (in_block),
    .round_keys (round_keys),
    .out_valid  (out_valid),
    .out_tag    (out_tag),
    .out_block  (out_block)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [LAT-1:0] vhist;
  logic [KSW-1:0] ks_hist [NR];
  logic [63:0]    exp_blk_q [$];
  logic [TW-1:0]  exp_tag_q [$];
  string          exp_req_q [$];

  function automatic logic [KSW-1:0] make_keys(input logic [63:0] key, input bit rev);
    logic [55:0] cd;
    logic [27:0] c;
    logic [27:0] d;
    logic [47:0] k;
    logic [KSW-1:0] ks;
    int slot;
    ks = '0;
    for (int i = 0; i < 56; i++) cd[55 - i] = key[64 - PC1_TAB[i]];
    c = cd[55:28];
    d = cd[27:0];
    for (int r = 0; r < NR; r++) begin
      for (int s = 0; s < ROT_TAB[r]; s++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
      cd = {c, d};
      for (int i = 0; i < 48; i++) k[47 - i] = cd[56 - PC2_TAB[i]];
      slot = rev ? (NR - 1 - r) : r;
      ks[slot*48 +: 48] = k;
    end
    return ks;
  endfunction

  function automatic logic [63:0] ref_cipher(input logic [63:0] blk, input logic [KSW-1:0] ks);
    logic [63:0] x;
    logic [31:0] l;
    logic [31:0] r;
    logic [31:0] t;
    logic [31:0] s;
    logic [47:0] e;
    x = perm_initial(blk);
    l = x[63:32];
    r = x[31:0];
    for (int rnd = 0; rnd < NR; rnd++) begin
      e = expand(r) ^ ks[rnd*48 +: 48];
      for (int g = 0; g < 8; g++) s[31 - 4*g -: 4] = sbox_out(g, e[47 - 6*g -: 6]);
      t = l ^ perm_p(s);
      l = r;
      r = t;
    end
    return perm_final({r, l});
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic observe();
    string req;
    req = vhist[LAT-1] ? "R2" : "R8";
    check(out_valid == vhist[LAT-1], req, 64'(out_valid), 64'(vhist[LAT-1]));
    if (out_valid && exp_blk_q.size() > 0) begin
      check(out_block == exp_blk_q[0], exp_req_q[0], out_block, exp_blk_q[0]);
      check(out_tag == exp_tag_q[0], "R4", 64'(out_tag), 64'(exp_tag_q[0]));
      void'(exp_blk_q.pop_front());
      void'(exp_tag_q.pop_front());
      void'(exp_req_q.pop_front());
    end else if (out_valid) begin
      check(1'b0, "R2", 64'(1), 64'(0));
    end
  endtask

  // One clock: observe outputs, then present a slot and skew the subkey bus
  task automatic step(input bit v, input logic [63:0] blk, input logic [TW-1:0] tag,
                      input logic [KSW-1:0] ks, input logic [63:0] exp, input string req);
    @(negedge clk);
    observe();
    rst = 1'b0;
    vhist = {vhist[LAT-2:0], v};
    for (int r = NR - 1; r > 0; r--) ks_hist[r] = ks_hist[r-1];
    ks_hist[0] = ks;
    for (int r = 0; r < NR; r++) round_keys[r*48 +: 48] = ks_hist[r][r*48 +: 48];
    in_valid = v;
    in_block = blk;
    in_tag   = tag;
    if (v) begin
      exp_blk_q.push_back(exp);
      exp_tag_q.push_back(tag);
      exp_req_q.push_back(req);
    end
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i > 0) check(out_valid == 1'b0, "R1", 64'(out_valid), 64'(0));
      rst = 1'b1;
      in_valid = 1'b0;
    end
    vhist = '0;
    for (int r = 0; r < NR; r++) ks_hist[r] = '0;
    exp_blk_q.delete();
    exp_tag_q.delete();
    exp_req_q.delete();
  endtask

  task automatic send_random(input bit v, input string req);
    logic [63:0]    key;
    logic [63:0]    blk;
    logic [TW-1:0]  tag;
    logic [KSW-1:0] ks;
    bit             dec;
    key = {$urandom, $urandom};
    blk = {$urandom, $urandom};
    tag = TW'($urandom);
    dec = 1'($urandom);
    ks  = v ? make_keys(key, dec) : '0;
    step(v, blk, tag, ks, v ? ref_cipher(blk, ks) : 64'h0, req);
  endtask

  initial begin
    rst        = 1'b1;
    in_valid   = 1'b0;
    in_tag     = '0;
    in_block   = '0;
    round_keys = '0;
    vhist      = '0;
    void'($urandom(32'h00C0DE5A));
    do_reset(4);
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'(0));

    // Bench model against the known answer before it is trusted
    check(ref_cipher(KAT_PT, make_keys(KAT_KEY, 1'b0)) == KAT_CT, "R6",
          ref_cipher(KAT_PT, make_keys(KAT_KEY, 1'b0)), KAT_CT);

    // Directed known answer: encrypt, then decrypt right behind it
    step(1'b1, KAT_PT, 2'd1, make_keys(KAT_KEY, 1'b0), KAT_CT, "R6");
    step(1'b1, KAT_CT, 2'd2, make_keys(KAT_KEY, 1'b1), KAT_PT, "R7");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, '0, 64'h0, "R8");

    // Back-to-back stream, fresh key and direction per block
    for (int i = 0; i < 48; i++) send_random(1'b1, "R3");

    // Gapped stream with garbage in idle slots
    for (int i = 0; i < 80; i++) send_random(1'($urandom), "R5");

    // Reset raised with the pipeline full: nothing in flight may emerge
    for (int i = 0; i < 10; i++) send_random(1'b1, "R5");
    do_reset(2);
    for (int i = 0; i < LAT + 3; i++) step(1'b0, {$urandom, $urandom}, 2'd0, '0, 64'h0, "R1");

    // Traffic after reset, then drain
    step(1'b1, KAT_PT, 2'd3, make_keys(KAT_KEY, 1'b0), KAT_CT, "R6");
    for (int i = 0; i < 20; i++) send_random(1'b1, "R5");
    for (int i = 0; i < LAT + 2; i++) step(1'b0, 64'h0, 2'd0, '0, 64'h0, "R8");

    check(exp_blk_q.size() == 0, "R2", 64'(exp_blk_q.size()), 64'(0));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule